// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves translation-buffer misses for a device-side address translation unit. When the buffer misses, the block takes the device virtual address, reads a first-level descriptor from an in-memory table whose base comes from a configuration input, and, if that descriptor points at a second-level table, reads a second descriptor. It then either returns the physical address and page size so the buffer can be refilled, or reports a fault. It serves one miss at a time and shows `busy` from the accepting edge until the result.

Four page sizes are resolved: 4 KB, 64 KB, 1 MB and 16 MB. The two larger sizes at each level are stored as sixteen identical copies in adjacent slots, and a hit on any copy yields the same translation. Faults record the virtual address and set one of two sticky status bits. Either bit raises the interrupt, and software clears a bit by writing 1 to it. Two enables gate the block: one for translation as a whole and one for table walking.

Top module: `ptw_walker`

## Requirements
- R1: After reset the block is idle, with `busy`, `rd_req`, `xlat_valid`, `fault_status`, `irq` and `fault_addr` all zero.
- R2: While `ctl_mmu_en` is 0, a miss request is ignored: no memory read, no `busy`, no status change.
- R3: With `ctl_mmu_en` at 1 and `ctl_walk_en` at 0, an accepted miss issues no memory read and sets `fault_status[0]` (miss fault) on the accepting edge.
- R4: The first read goes to `{tbl_base, va[31:20], 2'b00}`. First-level bits 1:0 decode as 01 = table pointer, 10 = section (bit 18 = 1 makes it a supersection), 00 or 11 = invalid, which sets `fault_status[1]` (translation fault).
- R5: A section gives `pa = {d[31:20], va[19:0]}` with `xlat_size` = 2. Size codes: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB.
- R6: A supersection gives `pa = {d[31:24], va[23:0]}` with size 3, from any of its 16 first-level copies.
- R7: For a table pointer, the second read goes to `{d[31:10], va[19:12], 2'b00}`. Second-level bits 1:0 decode as 01 = large page, 10 or 11 = small page (`pa = {e[31:12], va[11:0]}`, size 0), 00 = translation fault.
- R8: A large page gives `pa = {e[31:16], va[15:0]}` with size 1, from any of its 16 second-level copies.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_valid`. Each read ends on the edge where `rd_valid` is sampled high. `xlat_valid` (or a walk fault) appears in the cycle after the last read ends, and `busy` is high from acceptance up to that cycle.
- R10: On any fault, `fault_addr` takes the missing virtual address, and `irq` is the OR of the status bits.
- R11: Writing 1 in `fault_clr[i]` clears status bit i; a 0 leaves it unchanged; a fault setting the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mmu_en | input | 1 | Translation enable |
| ctl_walk_en | input | 1 | Table walking enable |
| tbl_base | input | 18 | First-level table base, address bits 31:14 |
| miss_valid | input | 1 | Miss request, accepted when idle |
| miss_va | input | 32 | Virtual address of the miss |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data (descriptor) |
| busy | output | 1 | Walk in progress |
| xlat_valid | output | 1 | One-cycle result pulse |
| xlat_pa | output | 32 | Translated physical address |
| xlat_size | output | 2 | Page size code |
| fault_status | output | 2 | Sticky status: bit 0 miss fault, bit 1 translation fault |
| fault_clr | input | 2 | Write-1-to-clear strobes for the status bits |
| fault_addr | output | 32 | Address of the latest fault |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
The bench builds the walker with its default parameters: a 12-bit first-level index and an 8-bit second-level index. This puts both tables at their full 4096- and 256-slot geometry, so a replicated supersection or large page can be hit in a slot other than its first. The bench's memory responder answers after 0 to 3 wait cycles. Together these reach the single-read and two-read paths, both invalid first-level codes, the empty second-level slot, and the result timing under every wait pattern.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTW_AW = 32;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        D1_BAD,
        D1_TABLE,
        D1_SECTION,
        D1_SUPER
    } l1_kind_e;

    typedef enum logic [1:0] {
        D2_BAD,
        D2_LARGE,
        D2_SMALL
    } l2_kind_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_LVL1,
        WS_LVL2
    } walk_state_e;

    typedef struct packed {
        logic [PTW_AW-1:0] pa;
        pg_size_e          size;
    } xlat_res_t;

    typedef struct packed {
        logic              hit;
        logic              is_xlat;
        logic [PTW_AW-1:0] va;
    } fault_ev_t;

    localparam int SUPER_BIT = 18;
    localparam int NUM_SIZES = 4;

    function automatic int page_shift(pg_size_e s);
        case (s)
            PG_4K:   return 12;
            PG_64K:  return 16;
            PG_1M:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic l1_kind_e decode_l1(logic [PTW_AW-1:0] d);
        case (d[1:0])
            2'b01:   return D1_TABLE;
            2'b10:   return d[SUPER_BIT] ? D1_SUPER : D1_SECTION;
            default: return D1_BAD;
        endcase
    endfunction

    function automatic l2_kind_e decode_l2(logic [PTW_AW-1:0] d);
        case (d[1:0])
            2'b00:   return D2_BAD;
            2'b01:   return D2_LARGE;
            default: return D2_SMALL;
        endcase
    endfunction

endpackage

// File: rtl/ptw_compose.sv
module ptw_compose
    import ptw_pkg::*;
(
    input  logic [PTW_AW-1:0] desc,
    input  logic [PTW_AW-1:0] va,
    input  pg_size_e          size,
    output logic [PTW_AW-1:0] pa
);
    localparam int MIN_SH = page_shift(PG_4K);

    logic [PTW_AW-1:0] cand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int SH = page_shift(pg_size_e'(g));
        assign cand[g] = {desc[PTW_AW-1:SH], va[SH-1:0]};
    end

    assign pa = cand[size];

    logic unused_desc_low;
    assign unused_desc_low = ^desc[MIN_SH-1:0];
endmodule

// File: rtl/ptw_fault.sv
module ptw_fault
    import ptw_pkg::*;
#(
    parameter int NFLT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  fault_ev_t         ev,
    input  logic [NFLT-1:0]   clr,
    output logic [NFLT-1:0]   status,
    output logic [PTW_AW-1:0] addr,
    output logic              irq
);
    logic [NFLT-1:0] set_bit;

    assign set_bit[0] = ev.hit && !ev.is_xlat;
    assign set_bit[1] = ev.hit &&  ev.is_xlat;

    for (genvar i = 0; i < NFLT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= set_bit[i] | (status[i] & ~clr[i]);
        end

        assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set_bit[i]) |=> !status[i]);
        assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !clr[i]) |=> status[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)         addr <= '0;
        else if (ev.hit) addr <= ev.va;
    end

    assign irq = |status;

    assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
        ev.hit |=> (addr == $past(ev.va)));
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mmu_en,
    input  logic                          walk_en,
    input  logic [PTW_AW-L1_IDX_W-3:0]    tbl_base,
    input  logic                          miss_valid,
    input  logic [PTW_AW-1:0]             miss_va,
    output logic                          rd_req,
    output logic [PTW_AW-1:0]             rd_addr,
    input  logic                          rd_valid,
    input  logic [PTW_AW-1:0]             rd_data,
    output logic                          busy,
    output logic                          res_valid,
    output xlat_res_t                     res,
    output fault_ev_t                     fev
);
    localparam int L1_BASE_LSB = L1_IDX_W + 2;
    localparam int L2_BASE_LSB = L2_IDX_W + 2;
    localparam int L1_IDX_LSB  = PTW_AW - L1_IDX_W;
    localparam int L2_IDX_LSB  = L1_IDX_LSB - L2_IDX_W;

    walk_state_e                    state, nxt;
    logic [PTW_AW-1:0]              va_q;
    logic [PTW_AW-L2_BASE_LSB-1:0]  l2base_q;
    logic                           fin;
    pg_size_e                       fin_size;
    logic [PTW_AW-1:0]              pa_c;
    logic                           accept;

    ptw_compose u_compose (
        .desc (rd_data),
        .va   (va_q),
        .size (fin_size),
        .pa   (pa_c)
    );

    assign accept = (state == WS_IDLE) && miss_valid && mmu_en;

    always_comb begin
        nxt        = state;
        fin        = 1'b0;
        fin_size   = PG_4K;
        fev.hit    = 1'b0;
        fev.is_xlat = 1'b0;
        fev.va     = va_q;
        case (state)
            WS_IDLE: begin
                fev.va = miss_va;
                if (accept) begin
                    if (walk_en) nxt = WS_LVL1;
                    else         fev.hit = 1'b1;
                end
            end
            WS_LVL1: begin
                if (rd_valid) begin
                    nxt = WS_IDLE;
                    case (decode_l1(rd_data))
                        D1_TABLE:   nxt = WS_LVL2;
                        D1_SECTION: begin fin = 1'b1; fin_size = PG_1M;  end
                        D1_SUPER:   begin fin = 1'b1; fin_size = PG_16M; end
                        default:    begin fev.hit = 1'b1; fev.is_xlat = 1'b1; end
                    endcase
                end
            end
            default: begin
                if (rd_valid) begin
                    nxt = WS_IDLE;
                    case (decode_l2(rd_data))
                        D2_LARGE: begin fin = 1'b1; fin_size = PG_64K; end
                        D2_SMALL: begin fin = 1'b1; fin_size = PG_4K;  end
                        default:  begin fev.hit = 1'b1; fev.is_xlat = 1'b1; end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            va_q      <= '0;
            l2base_q  <= '0;
            res_valid <= 1'b0;
            res.pa    <= '0;
            res.size  <= PG_4K;
        end else begin
            state     <= nxt;
            res_valid <= fin;
            if (accept)
                va_q <= miss_va;
            if (state == WS_LVL1 && rd_valid)
                l2base_q <= rd_data[PTW_AW-1:L2_BASE_LSB];
            if (fin) begin
                res.pa   <= pa_c;
                res.size <= fin_size;
            end
        end
    end

    always_comb begin
        case (state)
            WS_LVL1: rd_addr = {tbl_base, va_q[PTW_AW-1:L1_IDX_LSB], 2'b00};
            WS_LVL2: rd_addr = {l2base_q, va_q[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
            default: rd_addr = '0;
        endcase
    end

    assign rd_req = (state != WS_IDLE);
    assign busy   = (state != WS_IDLE);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    assert_mmu_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !mmu_en) |=> !busy);
    assert_walk_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_valid && mmu_en && !walk_en) |-> (fev.hit && !fev.is_xlat));
    assert_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(miss_valid && mmu_en && walk_en));
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        !(fin && fev.hit));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ctl_mmu_en,
    input  logic                       ctl_walk_en,
    input  logic [PTW_AW-L1_IDX_W-3:0] tbl_base,
    input  logic                       miss_valid,
    input  logic [PTW_AW-1:0]          miss_va,
    output logic                       rd_req,
    output logic [PTW_AW-1:0]          rd_addr,
    input  logic                       rd_valid,
    input  logic [PTW_AW-1:0]          rd_data,
    output logic                       busy,
    output logic                       xlat_valid,
    output logic [PTW_AW-1:0]          xlat_pa,
    output logic [1:0]                 xlat_size,
    output logic [1:0]                 fault_status,
    input  logic [1:0]                 fault_clr,
    output logic [PTW_AW-1:0]          fault_addr,
    output logic                       irq
);
    xlat_res_t res;
    fault_ev_t fev;

    ptw_fsm #(
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mmu_en     (ctl_mmu_en),
        .walk_en    (ctl_walk_en),
        .tbl_base   (tbl_base),
        .miss_valid (miss_valid),
        .miss_va    (miss_va),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .busy       (busy),
        .res_valid  (xlat_valid),
        .res        (res),
        .fev        (fev)
    );

    ptw_fault #(.NFLT(2)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .ev     (fev),
        .clr    (fault_clr),
        .status (fault_status),
        .addr   (fault_addr),
        .irq    (irq)
    );

    assign xlat_pa   = res.pa;
    assign xlat_size = res.size;

    assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
        irq == (fault_status != 2'b00));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_mmu_en = 1'b0, ctl_walk_en = 1'b0;
    logic [17:0] tbl_base = 18'h00010;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_va = '0;
    logic        rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        busy, xlat_valid, irq;
    logic [31:0] xlat_pa, fault_addr;
    logic [1:0]  xlat_size, fault_status;
    logic [1:0]  fault_clr = 2'b00;

    int n_chk = 0, n_fail = 0;
    int lat = 0;
    int rcnt = 0;
    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .ctl_mmu_en(ctl_mmu_en), .ctl_walk_en(ctl_walk_en),
        .tbl_base(tbl_base), .miss_valid(miss_valid), .miss_va(miss_va),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .xlat_valid(xlat_valid), .xlat_pa(xlat_pa), .xlat_size(xlat_size),
        .fault_status(fault_status), .fault_clr(fault_clr), .fault_addr(fault_addr),
        .irq(irq)
    );

    function automatic logic [31:0] rdm(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder: answers after lat wait cycles
    always @(negedge clk) begin
        if (rd_req) begin
            if (rcnt == lat) begin
                rd_valid <= 1'b1;
                rd_data  <= rdm(rd_addr);
                rcnt     <= 0;
            end else begin
                rd_valid <= 1'b0;
                rcnt     <= rcnt + 1;
            end
        end else begin
            rd_valid <= 1'b0;
            rcnt     <= 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-clock comparison of behavioural invariants
    always @(negedge clk) begin
        if (!rst) begin
            chk("R10 irq", {31'b0, irq}, {31'b0, fault_status != 2'b00});
            if (rd_req) chk("R9 req-busy", {31'b0, busy}, 32'h1);
        end
    end

    // Behavioural reference walk
    task automatic ref_walk(input logic [31:0] va, output bit flt,
                            output logic [31:0] pa, output logic [1:0] sz, output int reads);
        logic [31:0] d, e, a;
        flt = 0; pa = 0; sz = 0; reads = 1;
        a = 32'(tbl_base) * 32'd16384 + (va >> 20) * 4;
        d = rdm(a);
        if (d[1:0] == 2'b01) begin
            reads = 2;
            a = (d & 32'hFFFFFC00) + ((va >> 12) & 32'hFF) * 4;
            e = rdm(a);
            if (e[1:0] == 2'b00) flt = 1;
            else if (e[1:0] == 2'b01) begin pa = (e & 32'hFFFF0000) | (va & 32'h0000FFFF); sz = 1; end
            else begin pa = (e & 32'hFFFFF000) | (va & 32'h00000FFF); sz = 0; end
        end else if (d[1:0] == 2'b10) begin
            if (d[18]) begin pa = (d & 32'hFF000000) | (va & 32'h00FFFFFF); sz = 3; end
            else       begin pa = (d & 32'hFFF00000) | (va & 32'h000FFFFF); sz = 2; end
        end else flt = 1;
    endtask

    task automatic do_miss(string req, logic [31:0] va);
        bit flt; logic [31:0] pa; logic [1:0] sz; int reads, k; bit busy_ok;
        ref_walk(va, flt, pa, sz, reads);
        k = reads * (lat + 1) + 1;
        busy_ok = 1;
        @(negedge clk);
        miss_valid = 1'b1; miss_va = va;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        for (int n = 1; n < k; n++) begin
            if (!busy || xlat_valid) busy_ok = 0;
            @(negedge clk);
        end
        chk({req, " R9 busy during walk"}, {31'b0, busy_ok}, 32'h1);
        chk({req, " R9 idle at result"}, {31'b0, busy}, 32'h0);
        if (flt) begin
            chk({req, " no result on fault"}, {31'b0, xlat_valid}, 32'h0);
            chk({req, " R10 xlat status"}, {31'b0, fault_status[1]}, 32'h1);
            chk({req, " R10 fault addr"}, fault_addr, va);
        end else begin
            chk({req, " valid"}, {31'b0, xlat_valid}, 32'h1);
            chk({req, " pa"}, xlat_pa, pa);
            chk({req, " size"}, {30'b0, xlat_size}, {30'b0, sz});
        end
    endtask

    task automatic pulse_clr(logic [1:0] m);
        @(negedge clk); fault_clr = m;
        @(negedge clk); fault_clr = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Tables: L1 at 0x40000, one L2 table at 0x80000
        mem[32'h40000 + 32'h123*4] = 32'hABC00002;                  // section
        for (int s = 0; s < 16; s++)
            mem[32'h40000 + (32'h300 + s)*4] = 32'h7E040002;        // supersection
        mem[32'h40000 + 32'h456*4] = 32'h00080001;                  // table ptr
        mem[32'h80000 + 32'h78*4]  = 32'h9ABCD002;                  // small page
        mem[32'h80000 + 32'h79*4]  = 32'h1234F003;                  // small, code 11
        for (int s = 0; s < 16; s++)
            mem[32'h80000 + (32'hA0 + s)*4] = 32'h55550001;         // large page
        mem[32'h40000 + 32'hA00*4] = 32'h00000003;                  // invalid code 11

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 rd_req", {31'b0, rd_req}, 32'h0);
        chk("R1 xlat_valid", {31'b0, xlat_valid}, 32'h0);
        chk("R1 status", {30'b0, fault_status}, 32'h0);
        chk("R1 fault_addr", fault_addr, 32'h0);

        ctl_mmu_en = 1'b1; ctl_walk_en = 1'b1;
        lat = 0; do_miss("R4 R5 section", 32'h12345678);
        chk("R5 section pa value", xlat_pa, 32'hABC45678);
        lat = 2; do_miss("R6 super slot0", 32'h30000010);
        do_miss("R6 super slot10", 32'h30A1B2C3);
        chk("R6 super pa value", xlat_pa, 32'h7EA1B2C3);
        lat = 1; do_miss("R7 small", 32'h45678ABC);
        chk("R7 small pa value", xlat_pa, 32'h9ABCDABC);
        do_miss("R7 small code11", 32'h45679001);
        lat = 3; do_miss("R8 large slot0", 32'h456A0004);
        do_miss("R8 large slot12", 32'h456AC123);
        chk("R8 large pa value", xlat_pa, 32'h5555C123);

        lat = 0; do_miss("R7 L2 empty", 32'h45690000);
        chk("R10 status after L2 fault", {30'b0, fault_status}, 32'h2);
        pulse_clr(2'b00);
        chk("R11 zero write keeps", {30'b0, fault_status}, 32'h2);
        pulse_clr(2'b10);
        chk("R11 clear xlat", {30'b0, fault_status}, 32'h0);
        lat = 1; do_miss("R4 L1 code00", 32'h99900000);
        pulse_clr(2'b10);
        do_miss("R4 L1 code11", 32'hA0012345);
        pulse_clr(2'b10);

        // R3 walk disabled
        ctl_walk_en = 1'b0;
        @(negedge clk); miss_valid = 1'b1; miss_va = 32'h12345678;
        @(posedge clk); @(negedge clk); miss_valid = 1'b0;
        chk("R3 miss status", {30'b0, fault_status}, 32'h1);
        chk("R3 no read", {31'b0, rd_req}, 32'h0);
        chk("R3 not busy", {31'b0, busy}, 32'h0);
        chk("R3 R10 fault addr", fault_addr, 32'h12345678);

        // R11 set wins over clear
        @(negedge clk); miss_valid = 1'b1; miss_va = 32'h0BAD0000; fault_clr = 2'b01;
        @(posedge clk); @(negedge clk); miss_valid = 1'b0; fault_clr = 2'b00;
        chk("R11 set beats clear", {30'b0, fault_status}, 32'h1);
        chk("R11 addr updated", fault_addr, 32'h0BAD0000);
        pulse_clr(2'b01);
        chk("R11 clear miss bit", {30'b0, fault_status}, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        // R2 mmu disabled
        ctl_mmu_en = 1'b0; ctl_walk_en = 1'b1;
        @(negedge clk); miss_valid = 1'b1; miss_va = 32'h12345678;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk("R2 idle", {30'b0, busy, rd_req}, 32'h0);
        end
        miss_valid = 1'b0;
        chk("R2 status", {30'b0, fault_status}, 32'h0);
        chk("R2 fault addr", fault_addr, 32'h0BAD0000);

        ctl_mmu_en = 1'b1;
        lat = 3; do_miss("R9 section slow", 32'h123FFFFF);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule